// File: doc/BRIEF.md
# Reset Supervisor with Watchdog Timer

This block produces a system reset for a small controller from three causes: a digital flag saying the supply has dropped below its threshold, an active-low push-button input, and a watchdog. The watchdog expects the monitored line to change level periodically, and either a rising or a falling edge counts as activity. The line it watches is chosen by a parameter: either a shared serial data line, or a dedicated strobe pin. The reset is presented on two pull-enable outputs for open-drain pads, one for an active-high reset pin and one for an active-low reset pin. Both outputs carry the same internal reset state.

While any cause is present, reset stays asserted. After the last cause goes away, reset is held for a fixed stretch before it is released. Every cause ends with the same stretch: a supply recovery, the end of a button press, or a watchdog expiry. All durations are counted on a single-cycle `tick` strobe, so the same logic serves a slow time base on silicon and short counts in simulation. The block comes out of power-on with reset asserted, so the outputs are valid from the start.

Top module: `rst_supervisor`

## Requirements
- R1: While `por_n` is low and on the first cycle after it rises, `rst_hi_drive` and `rst_lo_pull` are both 1.
- R2: A 1 on `supply_low` sampled at a rising clock edge makes reset asserted after that edge.
- R3: Once no cause is present, reset is released after exactly `HOLD_TICKS` tick-qualified edges. A cause that appears before the release restarts the full count from zero.
- R4: `mr_n` passes through a two-flop synchronizer. A new level is accepted only after the synchronized value has differed from the accepted level on `DEB_TICKS` consecutive ticks, so a low pulse shorter than that is ignored.
- R5: An accepted low on `mr_n` keeps reset asserted. After `mr_n` returns high with `tick` held at 1, release comes `DEB_TICKS + 2 + HOLD_TICKS` edges later.
- R6: With reset released, the watchdog expires and asserts reset on the `WD_TICKS`-th tick with no edge seen on the monitored line. The line is synchronized by two flops, and a rising or a falling edge restarts the count.
- R7: The watchdog count is cleared and held while reset is asserted. After any release, a static line expires exactly `WD_TICKS` ticks later.
- R8: The parameter `WD_SRC_BUS` picks the monitored line: 1 selects `sda_in`, 0 selects `wdog_pin`. Activity on the other line has no effect on the watchdog.
- R9: `rst_hi_drive` and `rst_lo_pull` are equal on every cycle.
- R10: When `tick` is 0, no counter advances. A reset that is being held stays asserted for as long as `tick` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| tick | input | 1 | Time-base strobe, one cycle wide; all durations count it |
| supply_low | input | 1 | Digital flag, 1 while the supply is below threshold |
| mr_n | input | 1 | Manual reset push-button, active low, asynchronous |
| sda_in | input | 1 | Serial data line, watchdog source when `WD_SRC_BUS`=1 |
| wdog_pin | input | 1 | Dedicated strobe, watchdog source when `WD_SRC_BUS`=0 |
| rst_hi_drive | output | 1 | Enable for the active-high reset pad (1 = reset asserted) |
| rst_lo_pull | output | 1 | Pull-low enable for the active-low reset pad (1 = reset asserted) |

## Verification
The assertions assume that `supply_low` and `tick` are synchronous to `clk`, and that `por_n` is low from time zero until after the first edges. They also assume `tick` is a plain enable whose pattern is arbitrary. The stimulus drives every input on the falling clock edge. It holds `por_n` low for several cycles at the start, and mixes fixed tick rates with random tick patterns. The random phase varies button pulse lengths around the debounce limit, spaces line activity around the watchdog limit, and inserts rare supply dips, so that each counter is pushed to its boundary from both sides.

// File: rtl/rsup_pkg.sv
package rsup_pkg;
  // width of a counter that has to hold 0 .. n-1
  function automatic int cnt_width(input int n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction

  // true when a counter of the given limit is on its final value
  function automatic logic on_last(input int unsigned cnt, input int unsigned limit);
    return cnt == (limit - 1);
  endfunction
endpackage

// File: rtl/rst_sync2.sv
module rst_sync2 #(
  parameter int  STAGES = 2,
  parameter bit  INIT   = 1'b0
) (
  input  logic clk,
  input  logic por_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) chain[i] <= INIT;
        else if (i == 0) chain[i] <= d;
        else chain[i] <= chain[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/rst_debounce.sv
module rst_debounce
  import rsup_pkg::*;
#(
  parameter int DEB_TICKS = 20
) (
  input  logic clk,
  input  logic por_n,
  input  logic tick,
  input  logic raw_n,
  output logic level_n
);
  localparam int CW = cnt_width(DEB_TICKS);

  logic          sync_n;
  logic [CW-1:0] cnt;
  logic          differs;
  logic          accept_evt;

  rst_sync2 #(.STAGES(2), .INIT(1'b1)) u_sync (
    .clk(clk), .por_n(por_n), .d(raw_n), .q(sync_n)
  );

  assign differs    = sync_n != level_n;
  assign accept_evt = differs && tick && on_last(cnt, DEB_TICKS);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      level_n <= 1'b1;
      cnt     <= '0;
    end else if (!differs) begin
      cnt <= '0;
    end else if (tick) begin
      if (accept_evt) begin
        level_n <= sync_n;
        cnt     <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R4: the accepted level only moves on a tick
  a_r4_change_on_tick: assert property (@(posedge clk) disable iff (!por_n)
    (level_n != $past(level_n)) |-> $past(tick));
  // R4: the accepted level only moves after the synchronized input disagreed
  a_r4_change_needs_diff: assert property (@(posedge clk) disable iff (!por_n)
    (level_n != $past(level_n)) |-> (level_n == $past(sync_n)));
endmodule

// File: rtl/rst_wdog.sv
module rst_wdog
  import rsup_pkg::*;
#(
  parameter int WD_TICKS = 1600
) (
  input  logic clk,
  input  logic por_n,
  input  logic tick,
  input  logic hold,
  input  logic line,
  output logic wd_edge,
  output logic wd_fire
);
  localparam int CW = cnt_width(WD_TICKS);

  logic          line_s;
  logic          line_prev;
  logic [CW-1:0] cnt;

  rst_sync2 #(.STAGES(2), .INIT(1'b0)) u_sync (
    .clk(clk), .por_n(por_n), .d(line), .q(line_s)
  );

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) line_prev <= 1'b0;
    else        line_prev <= line_s;
  end

  assign wd_edge = line_s ^ line_prev;
  assign wd_fire = !hold && !wd_edge && tick && on_last(cnt, WD_TICKS);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)               cnt <= '0;
    else if (hold || wd_edge) cnt <= '0;
    else if (tick)            cnt <= on_last(cnt, WD_TICKS) ? '0 : cnt + 1'b1;
  end

  // R7: counter is cleared while reset is held
  a_r7_clear_in_reset: assert property (@(posedge clk) disable iff (!por_n)
    hold |=> (cnt == '0));
  // R6: any line edge restarts the count
  a_r6_edge_restarts: assert property (@(posedge clk) disable iff (!por_n)
    wd_edge |=> (cnt == '0));
  // R10: counter frozen without a tick, unless cleared
  a_r10_wd_frozen: assert property (@(posedge clk) disable iff (!por_n)
    (!tick && !hold && !wd_edge) |=> $stable(cnt));
endmodule

// File: rtl/rst_supervisor.sv
module rst_supervisor
  import rsup_pkg::*;
#(
  parameter int DEB_TICKS  = 20,
  parameter int WD_TICKS   = 1600,
  parameter int HOLD_TICKS = 200,
  parameter bit WD_SRC_BUS = 1'b1
) (
  input  logic clk,
  input  logic por_n,
  input  logic tick,
  input  logic supply_low,
  input  logic mr_n,
  input  logic sda_in,
  input  logic wdog_pin,
  output logic rst_hi_drive,
  output logic rst_lo_pull
);
  localparam int HW = cnt_width(HOLD_TICKS);

  logic          rst_q;
  logic [HW-1:0] hold_cnt;
  logic          mr_level_n;
  logic          wd_line;
  logic          wd_edge;
  logic          wd_fire;
  logic          cause;
  logic          release_evt;

  assign wd_line = WD_SRC_BUS ? sda_in : wdog_pin;

  rst_debounce #(.DEB_TICKS(DEB_TICKS)) u_deb (
    .clk(clk), .por_n(por_n), .tick(tick), .raw_n(mr_n), .level_n(mr_level_n)
  );

  rst_wdog #(.WD_TICKS(WD_TICKS)) u_wd (
    .clk(clk), .por_n(por_n), .tick(tick), .hold(rst_q), .line(wd_line),
    .wd_edge(wd_edge), .wd_fire(wd_fire)
  );

  assign cause       = supply_low || !mr_level_n || wd_fire;
  assign release_evt = rst_q && !cause && tick && on_last(hold_cnt, HOLD_TICKS);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      rst_q    <= 1'b1;
      hold_cnt <= '0;
    end else if (cause) begin
      rst_q    <= 1'b1;
      hold_cnt <= '0;
    end else if (rst_q && tick) begin
      if (release_evt) begin
        rst_q    <= 1'b0;
        hold_cnt <= '0;
      end else begin
        hold_cnt <= hold_cnt + 1'b1;
      end
    end
  end

  assign rst_hi_drive = rst_q;
  assign rst_lo_pull  = rst_q;

  // R2: supply flag forces reset on the next cycle
  a_r2_supply_asserts: assert property (@(posedge clk) disable iff (!por_n)
    supply_low |=> rst_q);
  // R5: accepted button press keeps reset
  a_r5_button_holds: assert property (@(posedge clk) disable iff (!por_n)
    !mr_level_n |=> rst_q);
  // R3: release only after a full quiet stretch
  a_r3_release_after_stretch: assert property (@(posedge clk) disable iff (!por_n)
    $fell(rst_q) |-> ($past(hold_cnt) == HW'(HOLD_TICKS-1)) && $past(!cause && tick));
  // R10: nothing moves on a cycle without tick and without cause
  a_r10_hold_frozen: assert property (@(posedge clk) disable iff (!por_n)
    (!tick && !cause) |=> $stable(rst_q) && $stable(hold_cnt));
  // R6: watchdog expiry asserts reset
  a_r6_fire_asserts: assert property (@(posedge clk) disable iff (!por_n)
    wd_fire |=> rst_q);
endmodule

// File: tb/rst_supervisor_tb.sv
module rst_supervisor_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DEB  = 3;
  localparam int WD   = 40;
  localparam int HOLD = 12;

  logic clk = 1'b0;
  logic por_n = 1'b0;
  logic tick = 1'b1;
  logic supply_low = 1'b0;
  logic mr_n = 1'b1;
  logic sda_rand = 1'b0;
  logic sda_feed = 1'b0;
  logic feed_en = 1'b0;
  logic wdog_pin = 1'b0;
  logic sda_in;
  logic rst_hi_drive, rst_lo_pull;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit done = 1'b0;

  assign sda_in = feed_en ? sda_feed : sda_rand;

  always #(CLK_PERIOD/2) clk = ~clk;

  rst_supervisor #(.DEB_TICKS(DEB), .WD_TICKS(WD), .HOLD_TICKS(HOLD), .WD_SRC_BUS(1'b1)) u_dut (
    .clk(clk), .por_n(por_n), .tick(tick), .supply_low(supply_low), .mr_n(mr_n),
    .sda_in(sda_in), .wdog_pin(wdog_pin), .rst_hi_drive(rst_hi_drive), .rst_lo_pull(rst_lo_pull)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  // expected release delay after a button returns high, tick steady
  function automatic int button_release_delay(input int deb, input int hold);
    return 2 + deb + hold;
  endfunction

  // ---------------- behavioural reference, written from the requirements
  bit m_ms1, m_ms2, m_acc, m_ws1, m_ws2, m_wp, m_rst;
  int m_dc, m_wc, m_hc;

  always @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      m_ms1 = 1; m_ms2 = 1; m_acc = 1; m_dc = 0;
      m_ws1 = 0; m_ws2 = 0; m_wp = 0; m_wc = 0;
      m_rst = 1; m_hc = 0;
    end else begin
      bit edge_seen, expire, any_cause;
      edge_seen = m_ws2 ^ m_wp;
      expire    = !m_rst && !edge_seen && tick && (m_wc == WD - 1);
      any_cause = supply_low || !m_acc || expire;
      if (m_ms2 == m_acc) m_dc = 0;
      else if (tick) begin
        if (m_dc == DEB - 1) begin m_acc = m_ms2; m_dc = 0; end
        else m_dc++;
      end
      m_ms2 = m_ms1; m_ms1 = mr_n;
      if (m_rst || edge_seen) m_wc = 0;
      else if (tick) m_wc = (m_wc == WD - 1) ? 0 : m_wc + 1;
      m_wp = m_ws2; m_ws2 = m_ws1; m_ws1 = sda_in;
      if (any_cause) begin m_rst = 1; m_hc = 0; end
      else if (m_rst && tick) begin
        if (m_hc == HOLD - 1) begin m_rst = 0; m_hc = 0; end
        else m_hc++;
      end
    end
  end

  // per-cycle comparison, sampled at the falling edge
  always @(negedge clk) begin
    cycles++;
    if (!done) begin
      check(rst_hi_drive === m_rst, "R3/R6 model", rst_hi_drive, m_rst);
      check(rst_hi_drive === rst_lo_pull, "R9 outputs agree", rst_lo_pull, rst_hi_drive);
    end
  end

  // keep-alive toggler on the monitored line, both polarities
  int fcnt = 0;
  always @(negedge clk) begin
    if (feed_en) begin
      fcnt++;
      if (fcnt >= 8) begin fcnt = 0; sda_feed <= ~sda_feed; end
    end
  end

  task automatic count_until(input logic want, input int cap, output int n);
    n = 0;
    while (rst_hi_drive !== want && n < cap) begin
      @(negedge clk); n++;
    end
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // watchdog on the bench itself
  initial begin
    while (cycles < 100000) @(negedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
    finish_run();
  end

  initial begin
    int n;
    void'($urandom(32'h5eed1234));
    // R1: reset state
    repeat (4) @(negedge clk);
    check(rst_hi_drive === 1'b1 && rst_lo_pull === 1'b1, "R1 reset during por", rst_hi_drive, 1);
    por_n = 1'b1;
    @(negedge clk);
    check(rst_hi_drive === 1'b1, "R1 first cycle after por", rst_hi_drive, 1);
    count_until(1'b0, 200, n);
    check(n == HOLD - 1, "R3 power-up stretch", n + 1, HOLD);
    feed_en = 1'b1;

    // R2 + R3: supply dip and exact stretch
    repeat (5) @(negedge clk);
    supply_low = 1'b1;
    @(negedge clk);
    check(rst_hi_drive === 1'b1, "R2 supply asserts", rst_hi_drive, 1);
    supply_low = 1'b0;
    count_until(1'b0, 200, n);
    check(n == HOLD, "R3 supply release", n, HOLD);

    // R3 restart: new cause halfway through the stretch
    supply_low = 1'b1; @(negedge clk); supply_low = 1'b0;
    repeat (HOLD/2) @(negedge clk);
    check(rst_hi_drive === 1'b1, "R3 mid stretch", rst_hi_drive, 1);
    supply_low = 1'b1; @(negedge clk); supply_low = 1'b0;
    count_until(1'b0, 200, n);
    check(n == HOLD, "R3 restarted stretch", n, HOLD);

    // R10: no tick freezes the stretch
    supply_low = 1'b1; @(negedge clk); supply_low = 1'b0; tick = 1'b0;
    repeat (3*HOLD) @(negedge clk);
    check(rst_hi_drive === 1'b1, "R10 frozen without tick", rst_hi_drive, 1);
    tick = 1'b1;
    count_until(1'b0, 200, n);
    check(n == HOLD, "R10 resumes on tick", n, HOLD);

    // R4: short button glitch ignored
    mr_n = 1'b0; repeat (DEB - 1) @(negedge clk); mr_n = 1'b1;
    n = 0;
    repeat (DEB + 6) begin @(negedge clk); if (rst_hi_drive) n++; end
    check(n == 0, "R4 glitch ignored", n, 0);

    // R5: long press holds reset, then button delay
    mr_n = 1'b0;
    repeat (3*DEB + 4) @(negedge clk);
    check(rst_hi_drive === 1'b1, "R5 held while pressed", rst_hi_drive, 1);
    repeat (2*HOLD) @(negedge clk);
    check(rst_hi_drive === 1'b1, "R5 held past stretch", rst_hi_drive, 1);
    feed_en = 1'b0;
    mr_n = 1'b1;
    count_until(1'b0, 400, n);
    check(n == button_release_delay(DEB, HOLD), "R5 release after press", n, button_release_delay(DEB, HOLD));

    // R6/R7/R8: static selected line expires in WD ticks, other line ignored
    n = 0;
    while (rst_hi_drive !== 1'b1 && n < 400) begin
      @(negedge clk); n++;
      if (n % 3 == 0) wdog_pin = ~wdog_pin;
    end
    check(n == WD, "R8 other line ignored / R6 expiry", n, WD);
    count_until(1'b0, 200, n);
    check(n == HOLD, "R6 expiry stretch", n, HOLD);
    // R7: long reset, then exact expiry window
    supply_low = 1'b1; repeat (2*WD) @(negedge clk); supply_low = 1'b0;
    count_until(1'b0, 200, n);
    count_until(1'b1, 400, n);
    check(n == WD, "R7 counter cleared in reset", n, WD);
    // R6: either edge keeps it alive
    feed_en = 1'b1;
    count_until(1'b0, 200, n);
    n = 0;
    repeat (3*WD) begin @(negedge clk); if (rst_hi_drive) n++; end
    check(n == 0, "R6 activity keeps alive", n, 0);

    // random phase, checked by the reference every cycle
    feed_en = 1'b0;
    repeat (40) begin
      int len;
      int kind;
      kind = $urandom % 6;
      len  = 1 + $urandom % (WD + 10);
      for (int i = 0; i < len; i++) begin
        tick = ($urandom % 4) != 0;
        if (kind == 0) supply_low = (i < 3);
        else supply_low = 1'b0;
        if (kind == 1) mr_n = !(i < (1 + $urandom % (2*DEB + 2)));
        else mr_n = 1'b1;
        if (kind >= 2 && ($urandom % (kind * 6)) == 0) sda_rand = ~sda_rand;
        if (($urandom % 5) == 0) wdog_pin = ~wdog_pin;
        @(negedge clk);
      end
    end
    supply_low = 1'b0; mr_n = 1'b1; tick = 1'b1;
    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule